// File: doc/BRIEF.md
# Local Memory Address Router

This block sits on a processor's data port and decides, for every request, which target serves it. The targets are a read-only boot ROM, a small instruction memory, a small data memory, main memory and an I/O space. The instruction and data windows are not fixed. The control block supplies them at run time as an instruction-window limit, a data-window base and a data-window size.

For the chosen target the router also produces the local offset. The two small memories repeat across their whole windows, because the offset is masked down to the memory's own size. The block does no waiting, holds no data path and raises no alignment fault.

The decision is made combinationally and registered once. The result for a request presented at one rising edge is visible on the outputs until the next edge.

Top module: `tcm_router`

## Requirements
- R1: While reset is asserted (`rst_n` low), and in the first cycle after it, `tgt_sel` is 0, `tgt_off` is 0 and `unmapped` is 0.
- R2: A cycle with `req_valid` low produces `tgt_sel` = 0, `tgt_off` = 0 and `unmapped` = 0 after the next edge.
- R3: A read (`is_write` = 0) whose address lies in the 64 KiB boot window starting at 0xFFFF0000 selects the boot ROM, whatever the other windows hold. Its offset is `addr & 0xFFF`.
- R4: A write to the boot window never selects the boot ROM. It is decoded as if the boot ROM did not exist.
- R5: An address below `imem_limit` selects the instruction memory, with offset `addr & 0x7FFF`. A limit of 0 disables this window.
- R6: An address `a` with `dmem_base <= a < dmem_base + dmem_size` selects the data memory, with offset `(a - dmem_base) & 0x3FFF`. The sum is formed in 33 bits, so a window near the top of the address space does not wrap. A size of 0 disables this window.
- R7: The order of precedence is: boot ROM (reads only), then instruction memory, then data memory, then the top-byte decode.
- R8: Otherwise, top byte 0x02 selects main memory with offset `addr & 0x3FFFFF`.
- R9: Otherwise, top byte 0x04 selects the I/O space with offset `addr & 0xFFFFFF`.
- R10: A valid request that matches no target raises `unmapped` for exactly the one cycle that reports it, with `tgt_sel` = 0 and `tgt_off` = 0, so that a read returns 0.
- R11: `tgt_sel` is one-hot or zero. The bit order is: bit 0 boot ROM, bit 1 instruction memory, bit 2 data memory, bit 3 main memory, bit 4 I/O. After every valid request, exactly one of `unmapped` and the bits of `tgt_sel` is set.
- R12: The outputs change only at a rising edge. They report the request sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| is_write | input | 1 | 1 for a write, 0 for a read |
| addr | input | 32 | Byte address of the request |
| imem_limit | input | 32 | Instruction window: addresses below this value hit |
| dmem_base | input | 32 | Start of the data window |
| dmem_size | input | 32 | Length of the data window in bytes, 0 disables it |
| tgt_sel | output | 5 | One-hot target select |
| tgt_off | output | 32 | Offset inside the selected target |
| unmapped | output | 1 | Request matched no target |

## Verification
The interesting overlaps are those where one address hits two windows in the same cycle. The bench builds several such overlaps: the instruction window spread over the data window, the data window placed over main memory, and the data window laid at the top of the space over the boot ROM. It then checks that only the higher-ranked target is selected, with that target's own offset. The same top-of-space address is sent once as a read and once as a write. This shows the boot ROM winning only for reads, and the non-wrapping data window taking the write.

// File: rtl/tcm_router.sv
module tcm_router #(
  parameter int          AW            = 32,
  parameter int          NT            = 5,
  parameter logic [31:0] BOOT_BASE     = 32'hFFFF_0000,
  parameter int          BOOT_SPAN_BITS = 16,
  parameter int          BOOT_OFF_BITS = 12,
  parameter int          IMEM_OFF_BITS = 15,
  parameter int          DMEM_OFF_BITS = 14,
  parameter int          MAIN_OFF_BITS = 22,
  parameter int          IO_OFF_BITS   = 24,
  parameter int          TAG_BITS      = 8,
  parameter logic [7:0]  MAIN_TAG      = 8'h02,
  parameter logic [7:0]  IO_TAG        = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] imem_limit,
  input  logic [AW-1:0] dmem_base,
  input  logic [AW-1:0] dmem_size,
  output logic [NT-1:0] tgt_sel,
  output logic [AW-1:0] tgt_off,
  output logic          unmapped
);

  localparam logic [AW-1:0] ONE       = AW'(1);
  localparam logic [AW-1:0] BOOT_SPAN = ~((ONE << BOOT_SPAN_BITS) - ONE);
  localparam logic [AW-1:0] BOOT_MSK  = (ONE << BOOT_OFF_BITS) - ONE;
  localparam logic [AW-1:0] IMEM_MSK  = (ONE << IMEM_OFF_BITS) - ONE;
  localparam logic [AW-1:0] DMEM_MSK  = (ONE << DMEM_OFF_BITS) - ONE;
  localparam logic [AW-1:0] MAIN_MSK  = (ONE << MAIN_OFF_BITS) - ONE;
  localparam logic [AW-1:0] IO_MSK    = (ONE << IO_OFF_BITS) - ONE;

  logic [AW:0]         dmem_end;
  logic                boot_hit, imem_hit, dmem_hit;
  logic [TAG_BITS-1:0] tag;
  logic [NT-1:0]       sel_d;
  logic [AW-1:0]       off_d;

  assign dmem_end = {1'b0, dmem_base} + {1'b0, dmem_size};
  assign boot_hit = !is_write && ((addr & BOOT_SPAN) == (BOOT_BASE & BOOT_SPAN));
  assign imem_hit = addr < imem_limit;
  assign dmem_hit = ({1'b0, addr} >= {1'b0, dmem_base}) && ({1'b0, addr} < dmem_end);
  assign tag      = addr[AW-1 -: TAG_BITS];

  always_comb begin
    sel_d = '0;
    off_d = '0;
    if (boot_hit) begin
      sel_d[0] = 1'b1;
      off_d    = addr & BOOT_MSK;
    end else if (imem_hit) begin
      sel_d[1] = 1'b1;
      off_d    = addr & IMEM_MSK;
    end else if (dmem_hit) begin
      sel_d[2] = 1'b1;
      off_d    = (addr - dmem_base) & DMEM_MSK;
    end else if (tag == MAIN_TAG) begin
      sel_d[3] = 1'b1;
      off_d    = addr & MAIN_MSK;
    end else if (tag == IO_TAG) begin
      sel_d[4] = 1'b1;
      off_d    = addr & IO_MSK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      tgt_sel  <= '0;
      tgt_off  <= '0;
      unmapped <= 1'b0;
    end else begin
      tgt_sel  <= sel_d;
      tgt_off  <= off_d;
      unmapped <= (sel_d == '0);
    end
  end

endmodule

// File: rtl/tcm_router_chk.sv
module tcm_router_chk #(
  parameter int          AW             = 32,
  parameter int          NT             = 5,
  parameter logic [31:0] BOOT_BASE      = 32'hFFFF_0000,
  parameter int          BOOT_SPAN_BITS = 16,
  parameter int          IMEM_OFF_BITS  = 15,
  parameter int          DMEM_OFF_BITS  = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          is_write,
  input logic [AW-1:0] addr,
  input logic [NT-1:0] tgt_sel,
  input logic [AW-1:0] tgt_off,
  input logic          unmapped
);

  localparam logic [AW-1:0] SPAN = ~((AW'(1) << BOOT_SPAN_BITS) - AW'(1));

  logic seen_q, boot_rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      boot_rd_q <= 1'b0;
    end else begin
      seen_q    <= req_valid;
      boot_rd_q <= req_valid && !is_write && ((addr & SPAN) == (BOOT_BASE & SPAN));
    end
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_sel));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q == ($countones({tgt_sel, unmapped}) == 1));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (tgt_sel == '0 && tgt_off == '0));

  // R3
  boot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rd_q |-> tgt_sel[0]);

  // R5
  imem_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[1] |-> (tgt_off >> IMEM_OFF_BITS) == '0);

  // R6
  dmem_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[2] |-> (tgt_off >> DMEM_OFF_BITS) == '0);

endmodule

bind tcm_router tcm_router_chk #(
  .AW(AW), .NT(NT), .BOOT_BASE(BOOT_BASE), .BOOT_SPAN_BITS(BOOT_SPAN_BITS),
  .IMEM_OFF_BITS(IMEM_OFF_BITS), .DMEM_OFF_BITS(DMEM_OFF_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_write(is_write),
  .addr(addr), .tgt_sel(tgt_sel), .tgt_off(tgt_off), .unmapped(unmapped)
);

// File: tb/sim_tcm_router.sv
module sim_tcm_router;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        v;
    logic        wr;
    logic [31:0] a;
    logic [31:0] il;
    logic [31:0] db;
    logic [31:0] ds;
    logic [4:0]  sel;
    logic [31:0] off;
    logic        unm;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R3 boot read
    '{1'b1, 1'b0, 32'hFFFF_0123, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00001, 32'h123, 1'b0, 8'd3},
    // R4 boot write falls through, unmapped
    '{1'b1, 1'b1, 32'hFFFF_0123, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b1, 8'd4},
    // R5 imem mirrored
    '{1'b1, 1'b0, 32'h0000_9234, 32'h1_0000, 32'h0080_0000, 32'h4000, 5'b00010, 32'h1234, 1'b0, 8'd5},
    // R5 limit edge
    '{1'b1, 1'b0, 32'h0000_8000, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b1, 8'd5},
    // R5 limit zero disables
    '{1'b1, 1'b0, 32'h0000_0000, 32'h0, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b1, 8'd5},
    // R6 dmem mirrored
    '{1'b1, 1'b0, 32'h0080_5678, 32'h8000, 32'h0080_0000, 32'h8000, 5'b00100, 32'h1678, 1'b0, 8'd6},
    // R6 end exclusive
    '{1'b1, 1'b0, 32'h0080_4000, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b1, 8'd6},
    // R6 last byte
    '{1'b1, 1'b1, 32'h0080_3FFF, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00100, 32'h3FFF, 1'b0, 8'd6},
    // R6 size zero disables
    '{1'b1, 1'b0, 32'h0080_0000, 32'h8000, 32'h0080_0000, 32'h0, 5'b00000, 32'h0, 1'b1, 8'd6},
    // R6 no wrap at top of space
    '{1'b1, 1'b1, 32'hFFFF_FFF0, 32'h8000, 32'hFFFF_FF00, 32'h200, 5'b00100, 32'hF0, 1'b0, 8'd6},
    // R7 boot read beats dmem
    '{1'b1, 1'b0, 32'hFFFF_FFF0, 32'h8000, 32'hFFFF_FF00, 32'h200, 5'b00001, 32'hFF0, 1'b0, 8'd7},
    // R7 imem beats dmem
    '{1'b1, 1'b0, 32'h0000_0100, 32'h100_0000, 32'h0, 32'h4000, 5'b00010, 32'h100, 1'b0, 8'd7},
    // R7 dmem when imem off
    '{1'b1, 1'b0, 32'h0000_0100, 32'h0, 32'h0, 32'h4000, 5'b00100, 32'h100, 1'b0, 8'd7},
    // R7 dmem beats main
    '{1'b1, 1'b0, 32'h0200_0010, 32'h8000, 32'h0200_0000, 32'h4000, 5'b00100, 32'h10, 1'b0, 8'd7},
    // R8 main
    '{1'b1, 1'b0, 32'h0234_5678, 32'h8000, 32'h0080_0000, 32'h4000, 5'b01000, 32'h34_5678, 1'b0, 8'd8},
    // R9 io
    '{1'b1, 1'b1, 32'h0400_0180, 32'h8000, 32'h0080_0000, 32'h4000, 5'b10000, 32'h180, 1'b0, 8'd9},
    // R10 unmapped
    '{1'b1, 1'b0, 32'h0300_0000, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b1, 8'd10},
    // R2 idle
    '{1'b0, 1'b0, 32'h0234_5678, 32'h8000, 32'h0080_0000, 32'h4000, 5'b00000, 32'h0, 1'b0, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, is_write = 1'b0;
  logic [31:0] addr = '0, imem_limit = '0, dmem_base = '0, dmem_size = '0;
  logic [4:0]  tgt_sel;
  logic [31:0] tgt_off;
  logic        unmapped;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcm_router u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_write(is_write),
    .addr(addr), .imem_limit(imem_limit), .dmem_base(dmem_base), .dmem_size(dmem_size),
    .tgt_sel(tgt_sel), .tgt_off(tgt_off), .unmapped(unmapped)
  );

  task automatic check(input string rq, input logic [4:0] es, input logic [31:0] eo, input logic eu);
    checks++;
    if (tgt_sel !== es || tgt_off !== eo || unmapped !== eu) begin
      errors++;
      $display("FAIL %s: sel=%b off=%h unm=%b expected sel=%b off=%h unm=%b",
               rq, tgt_sel, tgt_off, unmapped, es, eo, eu);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [31:0] a,
                       input logic [31:0] il, input logic [31:0] db, input logic [31:0] ds);
    @(negedge clk);
    req_valid = v; is_write = w; addr = a; imem_limit = il; dmem_base = db; dmem_size = ds;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset holds everything low even with a live request
    req_valid = 1'b1; addr = 32'h0234_5678;
    @(posedge clk); #1;
    check("R1", 5'b0, 32'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 5'b0, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v, VEC[i].wr, VEC[i].a, VEC[i].il, VEC[i].db, VEC[i].ds);
      check($sformatf("R%0d", VEC[i].rq), VEC[i].sel, VEC[i].off, VEC[i].unm);
    end

    // R10 unmapped lasts one cycle, then a mapped request clears it
    drive(1'b1, 1'b0, 32'h0700_0000, 32'h8000, 32'h0080_0000, 32'h4000);
    check("R10", 5'b0, 32'h0, 1'b1);
    drive(1'b1, 1'b0, 32'h0400_0004, 32'h8000, 32'h0080_0000, 32'h4000);
    check("R10", 5'b10000, 32'h4, 1'b0);

    // R12 new request not visible before the edge
    @(negedge clk);
    addr = 32'h0200_0008;
    #1;
    check("R12", 5'b10000, 32'h4, 1'b0);
    @(posedge clk); #1;
    check("R12", 5'b01000, 32'h8, 1'b0);

    // R11 after idle, no stale select
    drive(1'b0, 1'b0, 32'h0200_0008, 32'h8000, 32'h0080_0000, 32'h4000);
    check("R11", 5'b0, 32'h0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule